// File: doc/BRIEF.md
# Byte-wise DMA transfer and search engine

This block is a single-channel DMA engine with two ports, called A and B. It moves bytes one at a time from a source port to a destination port. Each port sits in memory space or in I/O space, and each port's address can count up, count down or stay fixed. On each byte the engine reads from the source. It can then write the byte to the destination, compare it against a masked pattern, or do both. A search that finds a match halts the engine. A byte counter, checked against a programmed block length, also ends the run.

All configuration inputs are captured on the start pulse. The engine then drives a simple request/acknowledge bus with a one-byte data path, so the slave can insert any number of wait states. In continuous mode the engine runs until a stop condition. In byte mode it moves one byte, then waits for a `step` pulse before each further byte. When the run stops, the engine can raise a one-cycle interrupt. The interrupt carries a vector that may include a status code, and a match takes priority over end-of-block.

The sequencer has five states:
- IDLE: waits for `start`.
- READ: source access.
- WRITE: destination access.
- CHECK: compare, count and stop decision.
- HOLD: byte-mode pause.

The transitions are:
- IDLE→READ on start.
- READ→WRITE on acknowledge when writing is enabled, READ→CHECK otherwise.
- WRITE→CHECK on acknowledge.
- CHECK→IDLE on a stop condition, CHECK→READ in continuous mode, CHECK→HOLD in byte mode.
- HOLD→READ on step.

Addresses step on the CHECK→READ and HOLD→READ transitions, but never before the first byte.

Top module: `bytedma_engine`

## Requirements
- R1: `ctrl[2]`=1 makes port A the source and port B the destination; `ctrl[2]`=0 makes port B the source and port A the destination.
- R2: In each port's 3-bit configuration, bit 0 selects I/O space (1) or memory space (0). Bit 2 holds the address fixed. When bit 2 is clear, bit 1 selects increment (1) or decrement (0).
- R3: The source is read on every byte. A destination write happens only when `ctrl[0]`=1, and it carries the byte just read.
- R4: When `ctrl[1]`=1, a byte matches if ((data XOR `pat_byte`) AND NOT `pat_mask`) is zero, so mask bits set to 1 are ignored. A match sets `match_flag` and stops the engine after that byte.
- R5: The first byte after a start uses the loaded addresses. Before every later byte, each non-fixed port address steps by one.
- R6: A byte counter, cleared at start, increments after each byte. With a nonzero `blk_len` L, the run ends after L+1 bytes, sets `end_flag` and stops.
- R7: When the counter wraps to zero (2^CNT_W bytes with `blk_len`=0), `end_flag` is set and the engine stops.
- R8: With `run_cont`=1, bytes move back to back until a stop condition. With `run_cont`=0, one byte moves after start and one more per `step` pulse.
- R9: At the stop, if `irq_enable`=1, `irq` pulses for one cycle. The code is 2 for a match when `irq_ctrl[0]`=1; otherwise it is 4 for end-of-block when `irq_ctrl[1]`=1. No pulse is raised when the code is 0.
- R10: `irq_vec` is (`irq_base` AND 0xF9) + code when `irq_ctrl[2]`=1, and `irq_base` unchanged otherwise.
- R11: `start` in IDLE clears `match_flag`, `end_flag`, the counter and the first-byte state, and raises `busy`. `busy` falls at the stop. `start` and the configuration inputs are ignored while busy.
- R12: `bus_req` stays high, with a stable address and direction, until `bus_ack`. Wait states only delay the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (captures configuration) |
| step | input | 1 | Byte-mode advance pulse |
| ctrl | input | 3 | [0] write enable, [1] search enable, [2] A is source |
| port_a_cfg | input | 3 | Port A: [0] I/O space, [1] increment, [2] fixed |
| port_b_cfg | input | 3 | Port B: same layout as port A |
| a_addr | input | AW | Port A start address |
| b_addr | input | AW | Port B start address |
| blk_len | input | CNT_W | Block length (0 = until counter wrap) |
| pat_byte | input | 8 | Search pattern |
| pat_mask | input | 8 | Search don't-care mask |
| run_cont | input | 1 | 1 = continuous, 0 = byte mode |
| irq_enable | input | 1 | Interrupt master enable |
| irq_ctrl | input | 3 | [0] match enable, [1] end enable, [2] status in vector |
| irq_base | input | 8 | Base interrupt vector |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_io | output | 1 | 1 = I/O space, 0 = memory |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |
| busy | output | 1 | Run in progress |
| match_flag | output | 1 | Search matched in last run |
| end_flag | output | 1 | Block end reached in last run |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_vec | output | 8 | Vector for the last interrupt |

## Verification
The bench first checks that a run of length L moves exactly L+1 bytes; a design that stops one byte short or one byte late shows a wrong read count. It checks where the first byte lands, because a design that steps addresses before the first byte shifts every destination by one. It drives a byte that both matches and hits the block end, which exposes a design that reports end-of-block instead of the match code. It also covers these cases:
- A masked compare, and a fully masked compare that must hit on the first byte.
- A fixed I/O destination.
- A start pulse during a byte-mode pause, which must not reload the addresses.
- A small-counter instance with zero length, which must stop exactly at the wrap.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_CHECK,
        S_HOLD
    } bdma_state_e;

    // ctrl bit positions
    localparam int CTL_WR   = 0;
    localparam int CTL_SRCH = 1;
    localparam int CTL_A2B  = 2;

    // port configuration bit positions
    localparam int PC_IO  = 0;
    localparam int PC_UP  = 1;
    localparam int PC_FIX = 2;

    // interrupt control bit positions
    localparam int IC_MATCH = 0;
    localparam int IC_END   = 1;
    localparam int IC_STAT  = 2;

    localparam logic [7:0] VEC_KEEP  = 8'hF9;
    localparam logic [7:0] CODE_HIT  = 8'd2;
    localparam logic [7:0] CODE_END  = 8'd4;
endpackage

// File: rtl/bdma_port_addr.sv
module bdma_port_addr
    import bdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] init,
    input  logic          adv,
    input  logic [2:0]    cfg,
    output logic [AW-1:0] addr,
    output logic          io_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= init;
        end else if (adv && !cfg[PC_FIX]) begin
            addr <= cfg[PC_UP] ? addr + 1'b1 : addr - 1'b1;
        end
    end

    assign io_sel = cfg[PC_IO];

    // R5
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(init));

    // R2
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cfg[PC_FIX]) |=> $stable(addr));
endmodule

// File: rtl/bdma_matcher.sv
module bdma_matcher (
    input  logic [7:0] data,
    input  logic [7:0] pattern,
    input  logic [7:0] dont_care,
    output logic       hit
);
    logic [7:0] diff;
    always_comb begin
        diff = (data ^ pattern) & ~dont_care;
        hit  = (diff == 8'h00);
    end
endmodule

// File: rtl/bdma_irq_vec.sv
module bdma_irq_vec
    import bdma_pkg::*;
(
    input  logic       hit_now,
    input  logic       end_now,
    input  logic [2:0] ictl,
    input  logic [7:0] base,
    output logic       fire,
    output logic [7:0] vec
);
    logic [7:0] code;
    always_comb begin
        if (hit_now && ictl[IC_MATCH]) begin
            code = CODE_HIT;
        end else if (end_now && ictl[IC_END]) begin
            code = CODE_END;
        end else begin
            code = 8'h00;
        end
        fire = (code != 8'h00);
        vec  = ictl[IC_STAT] ? (base & VEC_KEEP) + code : base;
    end
endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine
    import bdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [2:0]       ctrl,
    input  logic [2:0]       port_a_cfg,
    input  logic [2:0]       port_b_cfg,
    input  logic [AW-1:0]    a_addr,
    input  logic [AW-1:0]    b_addr,
    input  logic [CNT_W-1:0] blk_len,
    input  logic [7:0]       pat_byte,
    input  logic [7:0]       pat_mask,
    input  logic             run_cont,
    input  logic             irq_enable,
    input  logic [2:0]       irq_ctrl,
    input  logic [7:0]       irq_base,
    output logic             bus_req,
    output logic             bus_we,
    output logic             bus_io,
    output logic [AW-1:0]    bus_addr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    input  logic             bus_ack,
    output logic             busy,
    output logic             match_flag,
    output logic             end_flag,
    output logic             irq,
    output logic [7:0]       irq_vec
);
    localparam int NPORT = 2;

    bdma_state_e state, state_nx;

    logic [2:0]       ctl_q;
    logic [2:0]       pcfg_q [NPORT];
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [7:0]       pat_q, msk_q, base_q, dat_q;
    logic             cont_q, ien_q, stepped_q;
    logic [2:0]       ictl_q;
    logic             irq_q;
    logic [7:0]       vec_q;

    logic             ld, adv, stop, m_now, e_now, hit, wrap, len_hit;
    logic             fire;
    logic [7:0]       vec_w;
    logic [AW-1:0]    init_w [NPORT];
    logic [AW-1:0]    addr_w [NPORT];
    logic             io_w   [NPORT];
    logic             src_i, dst_i;

    assign init_w[0] = a_addr;
    assign init_w[1] = b_addr;
    assign src_i     = ctl_q[CTL_A2B] ? 1'b0 : 1'b1;
    assign dst_i     = ~src_i;

    // ---------------- per-port address units ----------------
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bdma_port_addr #(.AW(AW)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (ld),
            .init   (init_w[p]),
            .adv    (adv),
            .cfg    (pcfg_q[p]),
            .addr   (addr_w[p]),
            .io_sel (io_w[p])
        );
    end

    bdma_matcher u_match (
        .data      (dat_q),
        .pattern   (pat_q),
        .dont_care (msk_q),
        .hit       (hit)
    );

    // ---------------- stop evaluation ----------------
    always_comb begin
        cnt_nx  = cnt_q + 1'b1;
        wrap    = (cnt_nx == '0);
        len_hit = !wrap && (len_q != '0) && (cnt_q >= len_q);
        m_now   = ctl_q[CTL_SRCH] && hit;
        e_now   = wrap || len_hit;
        stop    = m_now || e_now;
    end

    bdma_irq_vec u_vec (
        .hit_now (m_now),
        .end_now (e_now),
        .ictl    (ictl_q),
        .base    (base_q),
        .fire    (fire),
        .vec     (vec_w)
    );

    assign ld  = (state == S_IDLE) && start;
    assign adv = stepped_q &&
                 (((state == S_CHECK) && !stop && cont_q) ||
                  ((state == S_HOLD) && step));

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_READ;
            S_READ:  if (bus_ack) state_nx = ctl_q[CTL_WR] ? S_WRITE : S_CHECK;
            S_WRITE: if (bus_ack) state_nx = S_CHECK;
            S_CHECK: begin
                if (stop)        state_nx = S_IDLE;
                else if (cont_q) state_nx = S_READ;
                else             state_nx = S_HOLD;
            end
            S_HOLD:  if (step) state_nx = S_READ;
            default: state_nx = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- run registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            pcfg_q[0]  <= '0;
            pcfg_q[1]  <= '0;
            len_q      <= '0;
            pat_q      <= '0;
            msk_q      <= '0;
            cont_q     <= 1'b0;
            ien_q      <= 1'b0;
            ictl_q     <= '0;
            base_q     <= '0;
            cnt_q      <= '0;
            dat_q      <= '0;
            stepped_q  <= 1'b0;
            match_flag <= 1'b0;
            end_flag   <= 1'b0;
            irq_q      <= 1'b0;
            vec_q      <= '0;
        end else begin
            irq_q <= 1'b0;
            if (ld) begin
                ctl_q      <= ctrl;
                pcfg_q[0]  <= port_a_cfg;
                pcfg_q[1]  <= port_b_cfg;
                len_q      <= blk_len;
                pat_q      <= pat_byte;
                msk_q      <= pat_mask;
                cont_q     <= run_cont;
                ien_q      <= irq_enable;
                ictl_q     <= irq_ctrl;
                base_q     <= irq_base;
                cnt_q      <= '0;
                stepped_q  <= 1'b0;
                match_flag <= 1'b0;
                end_flag   <= 1'b0;
            end
            if ((state == S_READ) && bus_ack) begin
                dat_q     <= bus_rdata;
                stepped_q <= 1'b1;
            end
            if (state == S_CHECK) begin
                cnt_q <= cnt_nx;
                if (m_now) match_flag <= 1'b1;
                if (e_now) end_flag   <= 1'b1;
                if (stop && ien_q && fire) begin
                    irq_q <= 1'b1;
                    vec_q <= vec_w;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_io    = 1'b0;
        bus_addr  = '0;
        bus_wdata = dat_q;
        unique case (state)
            S_READ: begin
                bus_req  = 1'b1;
                bus_addr = addr_w[src_i];
                bus_io   = io_w[src_i];
            end
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = addr_w[dst_i];
                bus_io   = io_w[dst_i];
            end
            default: ;
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign irq     = irq_q;
    assign irq_vec = vec_q;

    // R4
    match_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> !busy);

    // R6
    end_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> !busy);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag || end_flag) && !busy);

    // R3
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> ctl_q[CTL_WR]);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy && !match_flag && !end_flag);
endmodule

// File: tb/bytedma_engine_bench.sv
module bytedma_engine_bench;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [2:0]  ctl;
        logic [2:0]  pa;
        logic [2:0]  pb;
        logic [15:0] aa;
        logic [15:0] ab;
        logic [15:0] len;
        logic [7:0]  pat;
        logic [7:0]  msk;
        logic        cont;
        logic        ien;
        logic [2:0]  ictl;
        logic [7:0]  base;
        logic [3:0]  wt;
        logic [7:0]  n;
        logic        m;
        logic        e;
        logic        iq;
        logic [7:0]  vec;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // ctl   pa    pb    aa      ab      len     pat    msk    c  ie ictl  base   wt    n      m  e  iq vec
        '{3'd5, 3'd2, 3'd2, 16'h10, 16'h80, 16'd3,  8'h00, 8'h00, 1, 1, 3'd6, 8'h47, 4'd0, 8'd4, 0, 1, 1, 8'h45},
        '{3'd1, 3'd0, 3'd2, 16'hC0, 16'h40, 16'd2,  8'h00, 8'h00, 1, 1, 3'd2, 8'h30, 4'd1, 8'd3, 0, 1, 1, 8'h30},
        '{3'd6, 3'd2, 3'd2, 16'h20, 16'h90, 16'd20, 8'h70, 8'h00, 1, 1, 3'd7, 8'hFF, 4'd0, 8'd6, 1, 0, 1, 8'hFB},
        '{3'd7, 3'd2, 3'd5, 16'h30, 16'h40, 16'd5,  8'hA0, 8'h0F, 1, 1, 3'd7, 8'h10, 4'd2, 8'd6, 1, 1, 1, 8'h12},
        '{3'd5, 3'd5, 3'd2, 16'h05, 16'h90, 16'd1,  8'h00, 8'h00, 1, 0, 3'd7, 8'h00, 4'd3, 8'd2, 0, 1, 0, 8'h00},
        '{3'd6, 3'd2, 3'd2, 16'h00, 16'hA0, 16'd3,  8'hEE, 8'h00, 1, 1, 3'd1, 8'h55, 4'd0, 8'd4, 0, 1, 0, 8'h00},
        '{3'd6, 3'd2, 3'd2, 16'h50, 16'hA0, 16'd9,  8'h00, 8'hFF, 1, 1, 3'd1, 8'h88, 4'd0, 8'd1, 1, 0, 1, 8'h88}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, step = 1'b0, w_start = 1'b0;
    logic [2:0]  ctrl = '0, port_a_cfg = '0, port_b_cfg = '0, irq_ctrl = '0;
    logic [15:0] a_addr = '0, b_addr = '0, blk_len = '0;
    logic [7:0]  pat_byte = '0, pat_mask = '0, irq_base = '0;
    logic        run_cont = 1'b0, irq_enable = 1'b0;
    logic        bus_req, bus_we, bus_io, busy, match_flag, end_flag, irq;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, irq_vec;
    logic [7:0]  bus_rdata = '0;
    logic        bus_ack = 1'b0;

    logic        w_req, w_we, w_io, w_busy, w_match, w_end, w_irq;
    logic [15:0] w_addr;
    logic [7:0]  w_wdata, w_vec;

    logic [7:0]  mem [256];
    logic [7:0]  io  [256];
    int          checks = 0, fails = 0;
    int          rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, wait_n = 0, wcnt = 0, w_rd = 0;
    logic [7:0]  irq_seen = '0;
    logic        done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bytedma_engine u_bytedma_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .ctrl(ctrl), .port_a_cfg(port_a_cfg), .port_b_cfg(port_b_cfg),
        .a_addr(a_addr), .b_addr(b_addr), .blk_len(blk_len),
        .pat_byte(pat_byte), .pat_mask(pat_mask), .run_cont(run_cont),
        .irq_enable(irq_enable), .irq_ctrl(irq_ctrl), .irq_base(irq_base),
        .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .match_flag(match_flag), .end_flag(end_flag),
        .irq(irq), .irq_vec(irq_vec)
    );

    // small-counter instance for the wrap case, zero-wait bus
    bytedma_engine #(.AW(16), .CNT_W(4)) u_wrap (
        .clk(clk), .rst_n(rst_n), .start(w_start), .step(1'b0),
        .ctrl(3'd5), .port_a_cfg(3'd2), .port_b_cfg(3'd2),
        .a_addr(16'h0000), .b_addr(16'h0100), .blk_len(4'd0),
        .pat_byte(8'h00), .pat_mask(8'h00), .run_cont(1'b1),
        .irq_enable(1'b1), .irq_ctrl(3'd6), .irq_base(8'h00),
        .bus_req(w_req), .bus_we(w_we), .bus_io(w_io), .bus_addr(w_addr),
        .bus_wdata(w_wdata), .bus_rdata(8'h00), .bus_ack(w_req),
        .busy(w_busy), .match_flag(w_match), .end_flag(w_end),
        .irq(w_irq), .irq_vec(w_vec)
    );

    function automatic logic [7:0] mem_init(input logic [7:0] a);
        return a * 8'd3 + 8'd1;
    endfunction

    function automatic logic [7:0] io_init(input logic [7:0] a);
        return ~a;
    endfunction

    function automatic logic [7:0] addr_at(input logic [7:0] a0, input logic [2:0] cfg, input int k);
        if (cfg[2]) return a0;
        if (cfg[1]) return a0 + 8'(k);
        return a0 - 8'(k);
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic reinit();
        for (int i = 0; i < 256; i++) begin
            mem[i] = mem_init(8'(i));
            io[i]  = io_init(8'(i));
        end
    endtask

    // bus slave model and monitors, all at the falling edge
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= wait_n) begin
                bus_ack = 1'b1;
                wcnt = 0;
                if (bus_we) begin
                    wr_cnt++;
                    if (bus_io) io[bus_addr[7:0]] = bus_wdata;
                    else        mem[bus_addr[7:0]] = bus_wdata;
                end else begin
                    rd_cnt++;
                    bus_rdata = bus_io ? io[bus_addr[7:0]] : mem[bus_addr[7:0]];
                end
            end else begin
                wcnt++;
            end
        end
        if (irq) begin
            irq_cnt++;
            irq_seen = irq_vec;
        end
        if (w_req && !w_we) w_rd++;
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk({tag, " run finished"}, 32'd0, 32'd1);
        @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t vt;
        logic [7:0] sa, da, exp_d;
        logic [2:0] scfg, dcfg;

        reinit();
        wait_cycles(3);
        // R11 reset state
        chk("R11 busy after reset", 32'(busy), 32'd0);
        chk("R12 bus_req after reset", 32'(bus_req), 32'd0);
        chk("R9 irq after reset", 32'(irq), 32'd0);
        chk("R4 R6 flags after reset", {30'd0, match_flag, end_flag}, 32'd0);
        rst_n = 1'b1;
        wait_cycles(2);

        // ---------- vector table ----------
        for (int v = 0; v < NV; v++) begin
            vt = VECS[v];
            reinit();
            ctrl = vt.ctl; port_a_cfg = vt.pa; port_b_cfg = vt.pb;
            a_addr = vt.aa; b_addr = vt.ab; blk_len = vt.len;
            pat_byte = vt.pat; pat_mask = vt.msk; run_cont = vt.cont;
            irq_enable = vt.ien; irq_ctrl = vt.ictl; irq_base = vt.base;
            wait_n = int'(vt.wt);
            rd_cnt = 0; wr_cnt = 0; irq_cnt = 0; irq_seen = 8'h00;
            pulse_start();
            // R11 busy raised, flags cleared
            chk($sformatf("R11 busy during run v%0d", v), 32'(busy), 32'd1);
            chk($sformatf("R11 flags cleared v%0d", v), {30'd0, match_flag, end_flag}, 32'd0);
            wait_idle("R8");
            // R6 R4 R8 R12: number of bytes read
            chk($sformatf("R6 R4 R12 bytes read v%0d", v), 32'(rd_cnt), 32'(vt.n));
            // R3 write count
            chk($sformatf("R3 bytes written v%0d", v), 32'(wr_cnt), vt.ctl[0] ? 32'(vt.n) : 32'd0);
            chk($sformatf("R4 match_flag v%0d", v), 32'(match_flag), 32'(vt.m));
            chk($sformatf("R6 end_flag v%0d", v), 32'(end_flag), 32'(vt.e));
            chk($sformatf("R9 irq pulses v%0d", v), 32'(irq_cnt), 32'(vt.iq));
            if (vt.iq) chk($sformatf("R10 vector v%0d", v), 32'(irq_seen), 32'(vt.vec));
            // R1 R2 R5 destination contents
            if (vt.ctl[0]) begin
                sa   = vt.ctl[2] ? vt.aa[7:0] : vt.ab[7:0];
                da   = vt.ctl[2] ? vt.ab[7:0] : vt.aa[7:0];
                scfg = vt.ctl[2] ? vt.pa : vt.pb;
                dcfg = vt.ctl[2] ? vt.pb : vt.pa;
                for (int k = 0; k < int'(vt.n); k++) begin
                    if (!dcfg[2] || k == int'(vt.n) - 1) begin
                        exp_d = scfg[0] ? io_init(addr_at(sa, scfg, k)) : mem_init(addr_at(sa, scfg, k));
                        chk($sformatf("R1 R2 R5 dest byte %0d v%0d", k, v),
                            32'(dcfg[0] ? io[addr_at(da, dcfg, k)] : mem[addr_at(da, dcfg, k)]),
                            32'(exp_d));
                    end
                end
            end
        end

        // ---------- byte mode, with ignored start while paused ----------
        reinit();
        ctrl = 3'd5; port_a_cfg = 3'd2; port_b_cfg = 3'd2;
        a_addr = 16'h10; b_addr = 16'h80; blk_len = 16'd2;
        run_cont = 1'b0; irq_enable = 1'b0; wait_n = 0;
        rd_cnt = 0; wr_cnt = 0; irq_cnt = 0;
        pulse_start();
        wait_cycles(10);
        chk("R8 one byte then pause", 32'(rd_cnt), 32'd1);
        chk("R8 busy while paused", 32'(busy), 32'd1);
        chk("R5 first byte at loaded address", 32'(mem[8'h80]), 32'(mem_init(8'h10)));
        // R11: start while busy must not reload addresses
        a_addr = 16'h60; b_addr = 16'hE0;
        pulse_start();
        wait_cycles(5);
        chk("R11 start while busy ignored", 32'(rd_cnt), 32'd1);
        pulse_step();
        wait_cycles(10);
        chk("R8 one byte per step", 32'(rd_cnt), 32'd2);
        chk("R5 R11 second byte stepped, no reload", 32'(mem[8'h81]), 32'(mem_init(8'h11)));
        chk("R11 no write at ignored address", 32'(mem[8'hE0]), 32'(mem_init(8'hE0)));
        pulse_step();
        wait_idle("R8");
        chk("R8 R6 byte mode total", 32'(rd_cnt), 32'd3);
        chk("R6 byte mode end", 32'(end_flag), 32'd1);
        chk("R9 irq disabled", 32'(irq_cnt), 32'd0);

        // ---------- counter wrap ----------
        w_rd = 0; irq_cnt = 0;
        @(negedge clk);
        w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        for (int i = 0; i < 200 && w_busy; i++) @(negedge clk);
        @(negedge clk);
        chk("R7 bytes until counter wrap", 32'(w_rd), 32'd16);
        chk("R7 end_flag on wrap", 32'(w_end), 32'd1);
        chk("R7 R10 wrap vector", 32'(w_vec), 32'h04);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule